// File: doc/BRIEF.md
# Power Rail Fault Supervisor

The supervisor is the control state machine of a multi-rail power controller. It holds the rails off in a standby state. On a start request it turns the rails on one at a time in a programmed order and then stays active. It turns them off again in a second programmed order, either on request or when a serious fault appears. Each start request comes from a rising edge on a power-up pin or from a one-cycle register strobe. Each ordered stop request comes from a falling edge on the pin or from a register strobe. A programmable step delay sets the spacing between neighbouring rails in both sequences.

The supervisor sorts its fault flags into three classes. Shutdown-class faults are over-temperature, boost undervoltage, inverting converter undervoltage and input undervoltage lockout. Each of them triggers the ordered power-down. The immediate-class fault is the common-electrode supply fault. It drops every rail in one cycle and goes straight to standby. Warning-class faults are undervoltage on the four output rails. They leave the rails running and only pull power-good low. A rising edge on any fault flag produces a one-cycle event pulse for a separate interrupt block. That block returns a status signal that is high when no shutdown interrupt bit is pending. The supervisor refuses to start while that status is low, and after a fault it needs a fresh rising edge on the pin.

Top module: `rail_supervisor`

## Requirements
- R1: A shutdown-class flag seen while in power-up sequencing or active moves `state_o` to power-down sequencing on the next cycle, and the rails are then shut down to standby. The state encoding is 0 standby, 1 power-up sequencing, 2 active, 3 power-down sequencing.
- R2: In power-down sequencing the rails are cleared in the order given by `dn_order_i`, where entry k sits in bits [2k+1:2k] and names a rail index. The first rail clears one cycle after entry. Each following rail clears `step_dly_i`+1 cycles after the previous one. The state becomes standby in the cycle the last rail clears.
- R3: An immediate-class flag clears every rail and sets standby on the next cycle from any state. It takes priority over a shutdown-class flag in the same cycle.
- R4: Warning-class flags change neither the state nor the rail enables. While any of them is high, `pgood_o` is low. `pgood_o` returns high one cycle after they all clear.
- R5: No start request is accepted while `irq_clear_i` is low or while any shutdown-class or immediate-class flag is high.
- R6: The pin starts power-up only on a low-to-high transition, and only while in standby. A level that stays high, including one that is already high when reset is released, starts nothing.
- R7: A one-cycle `reg_up_i` strobe in standby starts power-up under the same conditions as a pin edge.
- R8: `pgood_o` is high only when, on the previous clock edge, all four rails were enabled and in regulation and no fault flag of any class was high. Otherwise it is low.
- R9: Power-up sequencing begins the cycle after an accepted start. The rails are enabled in `up_order_i` order (same packing as R2). The first rail turns on one cycle after entry and each following rail `step_dly_i`+1 cycles later. The state becomes active in the cycle the last rail turns on.
- R10: A rising edge on fault flag i sets bit i of the matching event output for exactly one cycle, one cycle later.
- R11: A shutdown-class flag during power-up sequencing aborts the sequence and starts the ordered power-down.
- R12: While active, a pin falling edge or a `reg_dn_i` strobe starts the ordered power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sd_flt_i | input | 4 | Shutdown-class fault flags |
| imm_flt_i | input | 1 | Immediate-class fault flag |
| warn_flt_i | input | 4 | Warning-class fault flags |
| rail_ok_i | input | 4 | Per-rail in-regulation flags |
| pwrup_i | input | 1 | Power-up pin, edge sensitive |
| reg_up_i | input | 1 | Register start strobe |
| reg_dn_i | input | 1 | Register stop strobe |
| irq_clear_i | input | 1 | High when no shutdown interrupt bit is pending |
| up_order_i | input | 8 | Power-up rail order, 2 bits per step |
| dn_order_i | input | 8 | Power-down rail order, 2 bits per step |
| step_dly_i | input | 8 | Extra cycles between sequence steps |
| rail_en_o | output | 4 | Per-rail enables |
| pgood_o | output | 1 | Power-good, low pulls the line down |
| state_o | output | 2 | Controller state |
| sd_evt_o | output | 4 | Shutdown-class fault event pulses |
| imm_evt_o | output | 1 | Immediate-class fault event pulse |
| warn_evt_o | output | 4 | Warning-class fault event pulses |

## Verification
On every cycle the assertions check that an immediate fault empties the rails in one step. They also check that a shutdown fault moves the controller into power-down, that at most one rail changes per cycle in either sequence, and that warnings leave the active state and rails untouched. They further check that a pending interrupt holds standby, that any rail off or out of regulation lowers power-good, and that event pulses last one cycle. The exact rail order, the step spacing, the rule that a held pin level must not restart, the register start path and the abort of a partial power-up can only be shown by the bench scenarios. Those scenarios use random orders and delays and compare against computed timing.

// File: rtl/rsup_pkg.sv
package rsup_pkg;
  typedef enum logic [1:0] {
    ST_STANDBY = 2'd0,
    ST_UP      = 2'd1,
    ST_ACTIVE  = 2'd2,
    ST_DOWN    = 2'd3
  } rsup_state_e;
endpackage

// File: rtl/rsup_edge.sv
module rsup_edge #(
  parameter int unsigned   W       = 1,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= RST_VAL;
    else         q <= d_i;
  end

  assign rise_o = d_i & ~q;
  assign fall_o = ~d_i & q;
endmodule

// File: rtl/rsup_fault_class.sv
module rsup_fault_class #(
  parameter int unsigned N_SD   = 4,
  parameter int unsigned N_WARN = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SD-1:0]   sd_flt_i,
  input  logic              imm_flt_i,
  input  logic [N_WARN-1:0] warn_flt_i,
  output logic              sd_any_o,
  output logic              imm_o,
  output logic              warn_any_o,
  output logic [N_SD-1:0]   sd_evt_o,
  output logic              imm_evt_o,
  output logic [N_WARN-1:0] warn_evt_o
);
  localparam int unsigned NF = N_SD + N_WARN + 1;

  logic [NF-1:0] flags, rise, fall_unused, evt_q;

  assign flags = {warn_flt_i, imm_flt_i, sd_flt_i};

  rsup_edge #(.W(NF), .RST_VAL('0)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (flags),
    .rise_o(rise),
    .fall_o(fall_unused)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= '0;
    else         evt_q <= rise;
  end

  assign sd_any_o   = |sd_flt_i;
  assign imm_o      = imm_flt_i;
  assign warn_any_o = |warn_flt_i;
  assign sd_evt_o   = evt_q[N_SD-1:0];
  assign imm_evt_o  = evt_q[N_SD];
  assign warn_evt_o = evt_q[NF-1:N_SD+1];

  p_evt_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_q) |=> ((evt_q & $past(evt_q)) == '0));
endmodule

// File: rtl/rsup_seq.sv
module rsup_seq
  import rsup_pkg::*;
#(
  parameter int unsigned N_RAILS = 4,
  parameter int unsigned IDX_W   = 2,
  parameter int unsigned DLY_W   = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     stop_i,
  input  logic                     sd_i,
  input  logic                     imm_i,
  input  logic [N_RAILS*IDX_W-1:0] up_order_i,
  input  logic [N_RAILS*IDX_W-1:0] dn_order_i,
  input  logic [DLY_W-1:0]         step_dly_i,
  output logic [N_RAILS-1:0]       rail_en_o,
  output rsup_state_e              state_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_RAILS - 1);

  rsup_state_e        state_q;
  logic [IDX_W-1:0]   idx_q;
  logic [DLY_W-1:0]   tmr_q;
  logic [N_RAILS-1:0] en_q;
  logic [IDX_W-1:0]   up_sel, dn_sel;
  logic               last;

  always_comb begin
    up_sel = '0;
    dn_sel = '0;
    for (int i = 0; i < N_RAILS; i++) begin
      if (idx_q == IDX_W'(i)) begin
        up_sel = up_order_i[i*IDX_W +: IDX_W];
        dn_sel = dn_order_i[i*IDX_W +: IDX_W];
      end
    end
  end

  assign last = (idx_q == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_STANDBY;
      idx_q   <= '0;
      tmr_q   <= '0;
      en_q    <= '0;
    end else if (imm_i) begin
      // immediate class bypasses any ordering
      state_q <= ST_STANDBY;
      en_q    <= '0;
      idx_q   <= '0;
      tmr_q   <= '0;
    end else begin
      case (state_q)
        ST_STANDBY: begin
          if (start_i) begin
            state_q <= ST_UP;
            idx_q   <= '0;
            tmr_q   <= '0;
          end
        end
        ST_UP: begin
          if (sd_i || stop_i) begin
            state_q <= ST_DOWN;
            idx_q   <= '0;
            tmr_q   <= '0;
          end else if (tmr_q != '0) begin
            tmr_q <= tmr_q - 1'b1;
          end else begin
            en_q[up_sel] <= 1'b1;
            if (last) begin
              state_q <= ST_ACTIVE;
              idx_q   <= '0;
            end else begin
              idx_q <= idx_q + 1'b1;
              tmr_q <= step_dly_i;
            end
          end
        end
        ST_ACTIVE: begin
          if (sd_i || stop_i) begin
            state_q <= ST_DOWN;
            idx_q   <= '0;
            tmr_q   <= '0;
          end
        end
        default: begin
          if (tmr_q != '0) begin
            tmr_q <= tmr_q - 1'b1;
          end else begin
            en_q[dn_sel] <= 1'b0;
            if (last) begin
              state_q <= ST_STANDBY;
              idx_q   <= '0;
            end else begin
              idx_q <= idx_q + 1'b1;
              tmr_q <= step_dly_i;
            end
          end
        end
      endcase
    end
  end

  assign rail_en_o = en_q;
  assign state_o   = state_q;

  p_imm_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imm_i |=> (en_q == '0 && state_q == ST_STANDBY));

  p_sd_down_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_UP || state_q == ST_ACTIVE) && sd_i && !imm_i) |=> (state_q == ST_DOWN));

  p_down_one_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DOWN && !imm_i) |=> ($countones(en_q ^ $past(en_q)) <= 1));

  p_up_one_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_UP && !imm_i) |=> ($countones(en_q ^ $past(en_q)) <= 1));

  p_standby_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DOWN && !imm_i) |=> ((en_q & ~$past(en_q)) == '0));
endmodule

// File: rtl/rsup_pgood.sv
module rsup_pgood #(
  parameter int unsigned N_RAILS = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_RAILS-1:0] rail_en_i,
  input  logic [N_RAILS-1:0] rail_ok_i,
  input  logic               fault_any_i,
  output logic               pgood_o
);
  logic [N_RAILS-1:0] rail_good;
  logic               pgood_q;

  for (genvar g = 0; g < N_RAILS; g++) begin : g_rail
    assign rail_good[g] = rail_en_i[g] & rail_ok_i[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pgood_q <= 1'b0;
    else         pgood_q <= (&rail_good) & ~fault_any_i;
  end

  assign pgood_o = pgood_q;

  p_pgood_rail_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rail_en_i != '1 || rail_ok_i != '1) |=> !pgood_o);

  p_pgood_fault_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_any_i |=> !pgood_o);
endmodule

// File: rtl/rail_supervisor.sv
module rail_supervisor
  import rsup_pkg::*;
#(
  parameter int unsigned N_RAILS = 4,
  parameter int unsigned N_SD    = 4,
  parameter int unsigned N_WARN  = 4,
  parameter int unsigned DLY_W   = 8,
  localparam int unsigned IDX_W  = (N_RAILS > 1) ? $clog2(N_RAILS) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_SD-1:0]          sd_flt_i,
  input  logic                     imm_flt_i,
  input  logic [N_WARN-1:0]        warn_flt_i,
  input  logic [N_RAILS-1:0]       rail_ok_i,
  input  logic                     pwrup_i,
  input  logic                     reg_up_i,
  input  logic                     reg_dn_i,
  input  logic                     irq_clear_i,
  input  logic [N_RAILS*IDX_W-1:0] up_order_i,
  input  logic [N_RAILS*IDX_W-1:0] dn_order_i,
  input  logic [DLY_W-1:0]         step_dly_i,
  output logic [N_RAILS-1:0]       rail_en_o,
  output logic                     pgood_o,
  output logic [1:0]               state_o,
  output logic [N_SD-1:0]          sd_evt_o,
  output logic                     imm_evt_o,
  output logic [N_WARN-1:0]        warn_evt_o
);
  logic        sd_any, imm_any, warn_any;
  logic        pin_rise, pin_fall;
  logic        start, stop;
  rsup_state_e state;

  rsup_fault_class #(.N_SD(N_SD), .N_WARN(N_WARN)) u_class (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sd_flt_i  (sd_flt_i),
    .imm_flt_i (imm_flt_i),
    .warn_flt_i(warn_flt_i),
    .sd_any_o  (sd_any),
    .imm_o     (imm_any),
    .warn_any_o(warn_any),
    .sd_evt_o  (sd_evt_o),
    .imm_evt_o (imm_evt_o),
    .warn_evt_o(warn_evt_o)
  );

  // reset value high: a pin already high at reset is not an edge
  rsup_edge #(.W(1), .RST_VAL(1'b1)) u_pin (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pwrup_i),
    .rise_o(pin_rise),
    .fall_o(pin_fall)
  );

  assign start = (pin_rise | reg_up_i) & irq_clear_i & ~sd_any & ~imm_any;
  assign stop  = pin_fall | reg_dn_i;

  rsup_seq #(.N_RAILS(N_RAILS), .IDX_W(IDX_W), .DLY_W(DLY_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .stop_i    (stop),
    .sd_i      (sd_any),
    .imm_i     (imm_any),
    .up_order_i(up_order_i),
    .dn_order_i(dn_order_i),
    .step_dly_i(step_dly_i),
    .rail_en_o (rail_en_o),
    .state_o   (state)
  );

  rsup_pgood #(.N_RAILS(N_RAILS)) u_pgood (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rail_en_i  (rail_en_o),
    .rail_ok_i  (rail_ok_i),
    .fault_any_i(sd_any | imm_any | warn_any),
    .pgood_o    (pgood_o)
  );

  assign state_o = state;

  p_no_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_STANDBY && (!irq_clear_i || sd_any)) |=> (state == ST_STANDBY));

  p_warn_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_ACTIVE && warn_any && !sd_any && !imm_any && !stop)
      |=> (state == ST_ACTIVE && rail_en_o == $past(rail_en_o)));

  p_held_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_STANDBY && !reg_up_i && $stable(pwrup_i)) |=> (state == ST_STANDBY));
endmodule

// File: tb/rail_supervisor_test.sv
module rail_supervisor_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] sd, warn, ok_force;
  logic       imm, pwrup, reg_up, reg_dn, irq_clr;
  logic [7:0] up_ord, dn_ord, dly;
  logic [3:0] rail_en, rail_ok, sd_evt, warn_evt;
  logic       pgood, imm_evt;
  logic [1:0] state;
  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign rail_ok = rail_en & ok_force;

  rail_supervisor uut (
    .clk_i(clk), .rst_ni(rst_n), .sd_flt_i(sd), .imm_flt_i(imm), .warn_flt_i(warn),
    .rail_ok_i(rail_ok), .pwrup_i(pwrup), .reg_up_i(reg_up), .reg_dn_i(reg_dn),
    .irq_clear_i(irq_clr), .up_order_i(up_ord), .dn_order_i(dn_ord), .step_dly_i(dly),
    .rail_en_o(rail_en), .pgood_o(pgood), .state_o(state), .sd_evt_o(sd_evt),
    .imm_evt_o(imm_evt), .warn_evt_o(warn_evt)
  );

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] perm();
    int a [4];
    logic [7:0] r;
    for (int i = 0; i < 4; i++) a[i] = i;
    for (int i = 3; i > 0; i--) begin
      int j, t;
      j = int'($urandom_range(i, 0));
      t = a[i]; a[i] = a[j]; a[j] = t;
    end
    for (int i = 0; i < 4; i++) r[i*2 +: 2] = 2'(a[i]);
    return r;
  endfunction

  task automatic run_up(input bit by_reg);
    logic [3:0] m = '0;
    if (by_reg) begin
      reg_up = 1'b1; tick(); reg_up = 1'b0;
      chk("R7 reg start", {30'd0, state}, 32'd1);
    end else begin
      pwrup = 1'b0; tick(); pwrup = 1'b1; tick();
      chk("R6 pin edge start", {30'd0, state}, 32'd1);
    end
    chk("R9 rails off at entry", {28'd0, rail_en}, 32'd0);
    for (int k = 0; k < 4; k++) begin
      if (k > 0) begin
        repeat (int'(dly)) tick();
        chk("R9 hold between steps", {28'd0, rail_en}, {28'd0, m});
      end
      tick();
      m[up_ord[k*2 +: 2]] = 1'b1;
      chk("R9 up step", {28'd0, rail_en}, {28'd0, m});
    end
    chk("R9 active after last", {30'd0, state}, 32'd2);
    chk("R8 pgood low same edge", {31'd0, pgood}, 32'd0);
    tick();
    chk("R8 pgood high", {31'd0, pgood}, 32'd1);
  endtask

  task automatic run_down(input int how, input int b);
    logic [3:0] m = 4'hF;
    if (how == 1 && pwrup == 1'b0) begin
      pwrup = 1'b1; tick();
      chk("R6 rise ignored when active", {30'd0, state}, 32'd2);
    end
    case (how)
      0: begin reg_dn = 1'b1; tick(); reg_dn = 1'b0; end
      1: begin pwrup = 1'b0; tick(); end
      default: begin
        sd[b] = 1'b1; irq_clr = 1'b0; tick(); sd = '0;
        chk("R10 sd event", {28'd0, sd_evt}, 32'(1 << b));
        chk("R8 pgood low on fault", {31'd0, pgood}, 32'd0);
      end
    endcase
    chk(how == 2 ? "R1 enter down" : "R12 enter down", {30'd0, state}, 32'd3);
    chk("R2 rails held at entry", {28'd0, rail_en}, 32'hF);
    for (int k = 0; k < 4; k++) begin
      if (k > 0) begin
        repeat (int'(dly)) tick();
        chk("R2 hold between steps", {28'd0, rail_en}, {28'd0, m});
      end
      tick();
      m[dn_ord[k*2 +: 2]] = 1'b0;
      chk("R2 down step", {28'd0, rail_en}, {28'd0, m});
      if (k == 0 && how == 2) chk("R10 pulse one cycle", {28'd0, sd_evt}, 32'd0);
    end
    chk("R1 standby after last", {30'd0, state}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_sim();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; sd = '0; warn = '0; imm = 1'b0; ok_force = 4'hF;
    pwrup = 1'b1; reg_up = 1'b0; reg_dn = 1'b0; irq_clr = 1'b1;
    up_ord = 8'b11_10_01_00; dn_ord = 8'b00_01_10_11; dly = 8'd2;
    tick(); tick();
    chk("R1 reset state", {30'd0, state}, 32'd0);
    chk("R8 reset rails/pgood", {27'd0, rail_en, pgood}, 32'd0);
    chk("R10 reset events", {23'd0, sd_evt, imm_evt, warn_evt}, 32'd0);
    rst_n = 1'b1;
    repeat (3) tick();
    chk("R6 high at reset ignored", {30'd0, state}, 32'd0);

    // R5: start blocked while a shutdown flag is present
    sd = 4'b0100; reg_up = 1'b1; tick(); reg_up = 1'b0; sd = '0; tick();
    chk("R5 blocked by fault flag", {30'd0, state}, 32'd0);

    for (int it = 0; it < 14; it++) begin
      int how;
      dly = 8'($urandom_range(4, 0));
      up_ord = perm();
      dn_ord = perm();
      run_up(1'($urandom_range(1, 0)));
      warn = 4'($urandom_range(15, 1));
      tick();
      chk("R4 warn keeps active", {26'd0, state, rail_en}, {26'd0, 2'd2, 4'hF});
      chk("R4 warn pgood low", {31'd0, pgood}, 32'd0);
      chk("R10 warn event", {28'd0, warn_evt}, {28'd0, warn});
      warn = '0; tick();
      chk("R4 warn recovers", {31'd0, pgood}, 32'd1);
      ok_force = ~(4'd1 << $urandom_range(3, 0)); tick();
      chk("R8 out of regulation", {29'd0, state, pgood}, {29'd0, 2'd2, 1'b0});
      ok_force = 4'hF; tick();
      chk("R8 regulation restored", {31'd0, pgood}, 32'd1);
      how = int'($urandom_range(2, 0));
      run_down(how, int'($urandom_range(3, 0)));
      if (how == 2) begin
        pwrup = 1'b0; tick(); pwrup = 1'b1; tick();
        chk("R5 blocked by pending irq", {30'd0, state}, 32'd0);
        irq_clr = 1'b1; repeat (3) tick();
        chk("R6 held level ignored", {30'd0, state}, 32'd0);
      end
    end

    // R3: immediate fault from active
    dly = 8'd1;
    run_up(1'b0);
    imm = 1'b1; irq_clr = 1'b0; tick(); imm = 1'b0;
    chk("R3 imm all off", {26'd0, state, rail_en}, 32'd0);
    chk("R10 imm event", {31'd0, imm_evt}, 32'd1);
    tick(); irq_clr = 1'b1;

    // R3: priority over a shutdown flag in the same cycle
    run_up(1'b1);
    imm = 1'b1; sd = 4'b0001; irq_clr = 1'b0; tick(); imm = 1'b0; sd = '0;
    chk("R3 imm wins over sd", {26'd0, state, rail_en}, 32'd0);
    tick(); irq_clr = 1'b1;

    // R11: shutdown during power-up aborts
    dly = 8'd3;
    reg_up = 1'b1; tick(); reg_up = 1'b0;
    tick();
    chk("R11 first rail on", {28'd0, rail_en}, 32'(1 << up_ord[1:0]));
    tick();
    sd = 4'b1000; irq_clr = 1'b0; tick(); sd = '0;
    chk("R11 abort to down", {30'd0, state}, 32'd3);
    repeat (4 * 4 + 2) tick();
    chk("R11 ends in standby", {26'd0, state, rail_en}, 32'd0);
    irq_clr = 1'b1;
    finish_sim();
  end
endmodule